// File: doc/BRIEF.md
# Answer-to-reset bit serializer

This block produces the answer-to-reset stream of a two-wire synchronous card interface. A host raises the card reset line. While that line is high the block clears its read address and fetches the first memory byte in advance. When the line falls, the block drives bit 0 of that byte onto the I/O line. Each later falling edge of the card clock moves the line to the next bit. The stream covers four bytes (`NBYTES`), sent least significant bit first within each byte and in rising address order. On the pulse that follows the last bit pulse, the block stops driving the line and leaves it released until the next reset.

The card-side inputs `card_rst`, `card_clk` and `io_in` must already be synchronous to `clk`; edges are found by comparing each input with its value in the previous cycle. Memory bytes come in through a read stream. The request side is valid/ready: `mem_req_valid` and `mem_req_addr` stay unchanged until `mem_req_ready` accepts them, unless a new card reset cancels the request. At most one read is in flight at a time. The response side is `mem_rsp_valid` with `mem_rsp_data` and has no back-pressure, so the block accepts every response. A response to a read that a card reset cancelled is thrown away.

The block also detects start conditions (I/O falls while the card clock is high) and stop conditions (I/O rises while the card clock is high) for the command logic that follows it. These conditions are suppressed while reset is high and while the stream is running.

Top module: `atr_serializer`

## Requirements
- R1: While `card_rst` is high, `io_oe` is low. The first read issued after reset is raised targets address `BASE_ADDR` (0 by default), which means the address counter has been cleared.
- R2: One `clk` cycle after `card_rst` is sampled low, `io_oe` is high and `io_out` carries bit 0 of byte 0.
- R3: The falling edges of card clock pulses 1 to 31 each present the next stream bit. Bit n of the stream is bit (n mod 8) of the byte at address n/8.
- R4: `io_out` changes only after a falling edge of `card_clk`. It holds its value through the clock high phase and through rising edges.
- R5: Pulse 32 leaves bit 31 on the line. The falling edge of pulse 33 drops `io_oe`, and `io_oe` stays low for any further pulses until the next reset.
- R6: Raising `card_rst` in the middle of a stream aborts it at once. The next release restarts the stream from byte 0, bit 0, and any read still in flight is discarded.
- R7: Start and stop conditions on `io_in` raise neither `cond_start` nor `cond_stop` while `card_rst` is high or while the stream is being driven, and they do not disturb the stream.
- R8: Once the stream has been released, a start condition pulses `cond_start` for one cycle, one cycle after it is sampled, and a stop condition does the same on `cond_stop`.
- R9: Each stream reads each of its bytes exactly once, in address order `BASE_ADDR` to `BASE_ADDR+NBYTES-1`, with one read in flight at most. The memory must answer byte 0 before reset is released, and each later byte before the bit boundary that needs it.
- R10: Whenever `io_oe` is low, `io_out` is 1, which is the idle level of the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| card_rst | input | 1 | Card reset line, synchronous to clk |
| card_clk | input | 1 | Card clock line, synchronous to clk |
| io_in | input | 1 | Sampled level of the card I/O line |
| io_out | output | 1 | Bit driven onto the I/O line |
| io_oe | output | 1 | Drive enable for the I/O line, low means released |
| mem_req_valid | output | 1 | Byte read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Byte address of the request |
| mem_rsp_valid | input | 1 | Read data valid, no back-pressure |
| mem_rsp_data | input | 8 | Read data byte |
| cond_start | output | 1 | One-cycle start condition pulse |
| cond_stop | output | 1 | One-cycle stop condition pulse |

## Verification
On every cycle, the assertions check four things: the line stays released while reset is high; it holds its value between card clock falling edges; conditions are masked throughout the answer-to-reset window; and the line is released only on pulse 33 and stays released afterwards. They also check that responses only follow an outstanding read and that each needed byte is present when it is consumed. Only the bench scenarios can show that the 32 bits match the memory contents in order, that an abort restarts the stream cleanly from byte 0, that exactly four reads at ascending addresses feed a stream, and that conditions are reported again once the stream is over.

// File: rtl/atr_pkg.sv
package atr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ARMED = 2'd1,
    PH_SHIFT = 2'd2,
    PH_DONE  = 2'd3
  } atr_phase_e;
endpackage

// File: rtl/atr_fetch.sv
module atr_fetch #(
  parameter int ADDR_W = 8,
  parameter int NBYTES = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              active,
  input  logic              take,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_data,
  output logic [7:0]        nxt_data,
  output logic              nxt_vld
);
  localparam int CW = $clog2(NBYTES + 1);
  localparam logic [CW-1:0] NB_C = CW'(NBYTES);

  logic [CW-1:0] fcnt_q;
  logic          outst_q;
  logic          drop_q;
  logic [7:0]    buf_q;
  logic          buf_v_q;

  assign mem_req_valid = active && !clear && !buf_v_q && !outst_q && (fcnt_q < NB_C);
  assign mem_req_addr  = BASE_ADDR + ADDR_W'(fcnt_q);
  assign nxt_data      = buf_q;
  assign nxt_vld       = buf_v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q  <= '0;
      outst_q <= 1'b0;
      drop_q  <= 1'b0;
      buf_q   <= '0;
      buf_v_q <= 1'b0;
    end else if (clear) begin
      fcnt_q  <= '0;
      buf_v_q <= 1'b0;
      if (mem_rsp_valid) begin
        outst_q <= 1'b0;
        drop_q  <= 1'b0;
      end else begin
        drop_q  <= outst_q;
      end
    end else begin
      if (mem_req_valid && mem_req_ready) begin
        outst_q <= 1'b1;
        fcnt_q  <= fcnt_q + 1'b1;
      end
      if (mem_rsp_valid) begin
        outst_q <= 1'b0;
        drop_q  <= 1'b0;
        if (!drop_q) begin
          buf_q   <= mem_rsp_data;
          buf_v_q <= 1'b1;
        end
      end else if (take) begin
        buf_v_q <= 1'b0;
      end
    end
  end

  AST_RSP_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> outst_q); // R9
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R9
endmodule

// File: rtl/atr_shifter.sv
module atr_shifter
  import atr_pkg::*;
#(
  parameter int NBYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       card_rst,
  input  logic       clk_fall,
  input  logic [7:0] nxt_data,
  input  logic       nxt_vld,
  output logic       take,
  output atr_phase_e phase,
  output logic       io_out,
  output logic       io_oe
);
  localparam int TOTAL_BITS = NBYTES * 8;
  localparam int PW = $clog2(TOTAL_BITS + 2);
  localparam logic [PW-1:0] LAST_P = PW'(TOTAL_BITS - 1);
  localparam logic [PW-1:0] REL_P  = PW'(TOTAL_BITS);

  atr_phase_e    phase_q;
  logic [7:0]    sh_q;
  logic [2:0]    bit_q;
  logic [PW-1:0] pcnt_q;
  logic          boundary;

  assign boundary = (phase_q == PH_SHIFT) && clk_fall && (pcnt_q < LAST_P) && (bit_q == 3'd7);
  assign take  = !card_rst && (((phase_q == PH_ARMED) && nxt_vld) || boundary);
  assign phase = phase_q;
  assign io_oe = (phase_q == PH_SHIFT);
  assign io_out = (phase_q == PH_SHIFT) ? sh_q[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      sh_q    <= '1;
      bit_q   <= '0;
      pcnt_q  <= '0;
    end else if (card_rst) begin
      phase_q <= PH_ARMED;
      bit_q   <= '0;
      pcnt_q  <= '0;
    end else begin
      case (phase_q)
        PH_ARMED: begin
          if (nxt_vld) begin
            phase_q <= PH_SHIFT;
            sh_q    <= nxt_data;
          end else begin
            phase_q <= PH_DONE;
          end
        end
        PH_SHIFT: begin
          if (clk_fall) begin
            pcnt_q <= pcnt_q + 1'b1;
            if (pcnt_q == REL_P) begin
              phase_q <= PH_DONE;
            end else if (pcnt_q < LAST_P) begin
              if (bit_q == 3'd7) begin
                sh_q  <= nxt_data;
                bit_q <= '0;
              end else begin
                sh_q  <= sh_q >> 1;
                bit_q <= bit_q + 3'd1;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_OE_LOW_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |=> !io_oe); // R1
  AST_BYTE0_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ARMED && !card_rst) |-> nxt_vld); // R9
  AST_NEXT_BYTE_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !card_rst) |-> nxt_vld); // R9
  AST_IO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SHIFT && !clk_fall && !card_rst) |=> $stable(io_out)); // R4
  AST_RELEASE_ON_33: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DONE && $past(phase_q) == PH_SHIFT) |-> $past(pcnt_q) == REL_P); // R5
  AST_STAYS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DONE && !card_rst) |=> !io_oe); // R5
endmodule

// File: rtl/atr_cond_det.sv
module atr_cond_det (
  input  logic clk,
  input  logic rst_n,
  input  logic card_clk,
  input  logic io_in,
  input  logic mask,
  output logic cond_start,
  output logic cond_stop
);
  logic ck_q;
  logic io_q;
  logic start_raw;
  logic stop_raw;

  assign start_raw = card_clk && ck_q && io_q && !io_in;
  assign stop_raw  = card_clk && ck_q && !io_q && io_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q       <= 1'b0;
      io_q       <= 1'b1;
      cond_start <= 1'b0;
      cond_stop  <= 1'b0;
    end else begin
      ck_q       <= card_clk;
      io_q       <= io_in;
      cond_start <= start_raw && !mask;
      cond_stop  <= stop_raw && !mask;
    end
  end

  AST_COND_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    mask |=> (!cond_start && !cond_stop)); // R7
endmodule

// File: rtl/atr_serializer.sv
module atr_serializer
  import atr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NBYTES = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              card_rst,
  input  logic              card_clk,
  input  logic              io_in,
  output logic              io_out,
  output logic              io_oe,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_data,
  output logic              cond_start,
  output logic              cond_stop
);
  logic       card_clk_q;
  logic       clk_fall;
  logic       clear;
  logic       active;
  logic       take;
  logic [7:0] nxt_data;
  logic       nxt_vld;
  atr_phase_e phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) card_clk_q <= 1'b0;
    else        card_clk_q <= card_clk;
  end

  assign clk_fall = card_clk_q && !card_clk;
  assign clear    = card_rst && (phase != PH_ARMED);
  assign active   = (phase == PH_ARMED) || (phase == PH_SHIFT);

  atr_fetch #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BASE_ADDR(BASE_ADDR)) u_fetch (
    .clk(clk), .rst_n(rst_n), .clear(clear), .active(active), .take(take),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .nxt_data(nxt_data), .nxt_vld(nxt_vld)
  );

  atr_shifter #(.NBYTES(NBYTES)) u_shift (
    .clk(clk), .rst_n(rst_n), .card_rst(card_rst), .clk_fall(clk_fall),
    .nxt_data(nxt_data), .nxt_vld(nxt_vld), .take(take), .phase(phase),
    .io_out(io_out), .io_oe(io_oe)
  );

  atr_cond_det u_cond (
    .clk(clk), .rst_n(rst_n), .card_clk(card_clk), .io_in(io_in),
    .mask(card_rst || active), .cond_start(cond_start), .cond_stop(cond_stop)
  );
endmodule

// File: tb/atr_serializer_bench.sv
module atr_serializer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic card_rst = 1'b0;
  logic card_clk = 1'b0;
  logic io_in = 1'b1;
  logic io_out, io_oe;
  logic mem_req_valid, mem_req_ready;
  logic [7:0] mem_req_addr;
  logic mem_rsp_valid;
  logic [7:0] mem_rsp_data;
  logic cond_start, cond_stop;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [7:0] mem [0:255];
  logic [7:0] req_log [0:15];
  int req_n = 0;
  int n_start = 0;
  int n_stop = 0;
  logic pend = 1'b0;
  logic [7:0] paddr = '0;
  int lat = 0;

  always #4 clk = ~clk;

  atr_serializer u_atr_serializer (
    .clk(clk), .rst_n(rst_n), .card_rst(card_rst), .card_clk(card_clk),
    .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .cond_start(cond_start), .cond_stop(cond_stop)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      mem_req_ready <= 1'b0;
      pend = 1'b0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mem[paddr];
          pend = 1'b0;
        end else lat = lat - 1;
      end
      if (mem_req_valid && mem_req_ready) begin
        pend = 1'b1;
        paddr = mem_req_addr;
        lat = int'($urandom_range(0, 3));
        if (req_n < 16) req_log[req_n] = mem_req_addr;
        req_n = req_n + 1;
      end
      mem_req_ready <= ($urandom_range(0, 2) != 0);
    end
  end

  always @(posedge clk) begin
    if (cond_start) n_start = n_start + 1;
    if (cond_stop)  n_stop  = n_stop + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int i);
    return mem[i / 8][i % 8];
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one card clock pulse; glitch adds a start and a stop condition in the high phase
  task automatic pulse(input bit glitch, input bit check_hold, input logic prev);
    card_clk = 1'b1;
    wclk(int'($urandom_range(2, 4)));
    if (glitch) begin
      io_in = 1'b0; wclk(2);
      io_in = 1'b1; wclk(2);
    end
    if (check_hold) chk(io_out === prev && io_oe === 1'b1, "R4 hold through high phase", int'(io_out), int'(prev));
    card_clk = 1'b0;
    wclk(2);
  endtask

  task automatic run_stream(input bit glitch);
    logic prev;
    card_rst = 1'b1;
    req_n = 0;
    wclk(2);
    chk(io_oe === 1'b0, "R1 R6 released under reset", int'(io_oe), 0);
    chk(io_out === 1'b1, "R10 idle level", int'(io_out), 1);
    wclk(18);
    chk(req_n >= 1 && req_log[0] == 8'd0, "R1 first read at address 0", int'(req_log[0]), 0);
    n_start = 0; n_stop = 0;
    card_rst = 1'b0;
    wclk(2);
    chk(io_oe === 1'b1, "R2 drive after release", int'(io_oe), 1);
    chk(io_out === exp_bit(0), "R2 bit 0", int'(io_out), int'(exp_bit(0)));
    prev = io_out;
    for (int p = 1; p <= 33; p++) begin
      pulse(glitch, 1'b1, prev);
      if (p <= 31)
        chk(io_out === exp_bit(p) && io_oe, "R3 stream bit", int'(io_out), int'(exp_bit(p)));
      else if (p == 32)
        chk(io_out === exp_bit(31) && io_oe, "R5 pulse 32 holds bit 31", int'(io_out), int'(exp_bit(31)));
      else
        chk(io_oe === 1'b0, "R5 release on pulse 33", int'(io_oe), 0);
      prev = io_out;
      wclk(int'($urandom_range(2, 4)));
    end
    for (int e = 0; e < 3; e++) pulse(1'b0, 1'b0, 1'b0);
    chk(io_oe === 1'b0 && io_out === 1'b1, "R5 R10 stays released", int'(io_oe), 0);
    chk(req_n == 4, "R9 read count", req_n, 4);
    for (int k = 0; k < 4; k++)
      chk(req_log[k] == 8'(k), "R9 read order", int'(req_log[k]), k);
    if (glitch) begin
      chk(n_start == 0 && n_stop == 0, "R7 conditions masked", n_start + n_stop, 0);
    end
  endtask

  task automatic partial(input int npulses);
    card_rst = 1'b1; req_n = 0; wclk(20);
    card_rst = 1'b0; wclk(2);
    for (int p = 0; p < npulses; p++) begin
      pulse(1'b0, 1'b0, 1'b0);
      wclk(2);
    end
  endtask

  task automatic rand_head();
    for (int k = 0; k < 4; k++) mem[k] = 8'($urandom);
  endtask

  initial begin
    void'($urandom(32'd20250611));
    for (int a = 0; a < 256; a++) mem[a] = 8'($urandom);
    wclk(3);
    chk(io_oe === 1'b0 && io_out === 1'b1, "R10 reset state", int'(io_oe), 0);
    rst_n = 1'b1;
    wclk(2);
    chk(cond_start === 1'b0 && cond_stop === 1'b0, "R8 quiet after reset", int'(cond_start), 0);

    mem[0] = 8'h00; mem[1] = 8'hFF; mem[2] = 8'hA5; mem[3] = 8'h5A;
    run_stream(1'b0);
    rand_head(); run_stream(1'b0);
    rand_head(); run_stream(1'b1);
    // R6: aborts at several points, each followed by a full stream
    rand_head(); partial(5);  run_stream(1'b0);
    rand_head(); partial(7);  run_stream(1'b0);
    rand_head(); partial(32); run_stream(1'b1);
    for (int s = 0; s < 4; s++) begin
      rand_head(); run_stream(s[0]);
    end

    // R8: conditions reported once released
    n_start = 0; n_stop = 0;
    card_clk = 1'b1; wclk(3);
    io_in = 1'b0; wclk(3);
    chk(n_start == 1, "R8 start reported", n_start, 1);
    io_in = 1'b1; wclk(3);
    chk(n_stop == 1, "R8 stop reported", n_stop, 1);
    card_clk = 1'b0; wclk(3);
    // R7: masked while reset high
    card_rst = 1'b1; card_clk = 1'b1; wclk(3);
    io_in = 1'b0; wclk(3); io_in = 1'b1; wclk(3);
    chk(n_start == 1 && n_stop == 1, "R7 masked under reset", n_start + n_stop, 2);
    card_clk = 1'b0; wclk(2);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule